// File: doc/BRIEF.md
# Tile-Preserving Decimating Window Address Generator

This block walks the pixels of a rectangular window of interest and presents one row address and one column address at a time. The readout timing pulses `step` once per pixel consumed; the generator then moves to the next address to read. Each direction has its own decimation rate, from full down to one in eight. The rate can be applied to single pixels (monochrome space) or to whole 2×2 colour tiles (Bayer space). In Bayer space the colour mosaic survives in the reduced image: every tile keeps green/red on its even row and blue/green on its odd row.

Rows are visited either in one sequential pass (progressive) or split into two interlaced fields. Field 0 takes the first, third, fifth… of the rows the decimation keeps. Field 1 takes the second, fourth… rows. Two fields make a frame. A one-cycle `row_done` pulse marks the end of each row. A one-cycle `field_done` pulse marks the end of each field. `field_par` names the field that is being read. After the last pixel of a field, the generator wraps to the first pixel of the next field by itself. Pixel data never passes through the block.

Top module: `subsample_addr_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `col_addr` equals `col_org`, `row_addr` equals `row_org`, and `row_done`, `field_done` and `field_par` are 0.
- R2: In a cycle where `step` is 0, the addresses and `field_par` stay unchanged. `row_done` and `field_done` are 0 in the following cycle.
- R3: In monochrome space (`bayer`=0), code k on `col_code` or `row_code` (00 full, 01 half, 10 quarter, 11 eighth) keeps the offsets from the window origin that are multiples of 2^k.
- R4: In Bayer space (`bayer`=1), code k keeps the offsets o where o mod 2^(k+1) is 0 or 1. This keeps two adjacent pixels and then skips 2(2^k−1) pixels.
- R5: No address lies at or beyond origin plus window size in its direction. A tile cut by the window edge is truncated.
- R6: Within a row, kept columns are visited in ascending order. The step that leaves the last kept column returns the column to `col_org`, moves to the next row of the field, and raises `row_done` for exactly the next cycle.
- R7: In progressive mode (`interlace`=0), every kept row is visited in ascending order in one field. The step that leaves the last pixel raises `field_done` together with `row_done`, and the generator returns to the first kept row.
- R8: In interlaced mode (`interlace`=1), the field with `field_par`=0 visits kept rows 1st, 3rd, 5th… in ascending order. The field with `field_par`=1 visits kept rows 2nd, 4th…
- R9: `field_par` inverts in the cycle `field_done` is raised when `interlace` is 1. It stays 0 when `interlace` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance to the next address |
| col_org | input | AW | First column of the window |
| row_org | input | AW | First row of the window |
| win_w | input | AW | Window width in pixels (at least 1) |
| win_h | input | AW | Window height in rows (at least 1) |
| col_code | input | 2 | Horizontal decimation code |
| row_code | input | 2 | Vertical decimation code |
| bayer | input | 1 | 1 = decimate whole 2×2 tiles, 0 = single pixels |
| interlace | input | 1 | 1 = two interlaced fields, 0 = progressive |
| col_addr | output | AW | Current column address |
| row_addr | output | AW | Current row address |
| row_done | output | 1 | One-cycle pulse after a row completes |
| field_done | output | 1 | One-cycle pulse after a field completes |
| field_par | output | 1 | Field being read (0 or 1) |

## Verification
The assertions assume that the window configuration and mode inputs hold still between resets. They also assume that origin plus size fits in AW bits, and that in interlaced mode the window keeps at least two rows so that both fields are non-empty. The bench sets every configuration only while reset is held, and picks window sizes inside these limits. It then walks whole fields, and the column and row lists it expects come from the keep rules of R3 and R4 applied offset by offset.

// File: rtl/subsample_addr_seq.sv
module subsample_addr_seq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [AW-1:0] col_org,
  input  logic [AW-1:0] row_org,
  input  logic [AW-1:0] win_w,
  input  logic [AW-1:0] win_h,
  input  logic [1:0]    col_code,
  input  logic [1:0]    row_code,
  input  logic          bayer,
  input  logic          interlace,
  output logic [AW-1:0] col_addr,
  output logic [AW-1:0] row_addr,
  output logic          row_done,
  output logic          field_done,
  output logic          field_par
);
  localparam int NW = AW + 2;

  logic [AW-1:0] col_off, row_off, first_row;
  logic [NW-1:0] c_nxt, r_one, r_two, r_nxt;
  logic          c_end, r_end, par_nxt;

  // next kept offset: pixel stride, or pair-then-skip in tile space
  function automatic logic [NW-1:0] adv(input logic [NW-1:0] o,
                                        input logic [1:0] code,
                                        input logic bay);
    logic [NW-1:0] s;
    s = NW'(1) << code;
    if (!bay)      return o + s;
    else if (o[0]) return o + (s << 1) - NW'(1);
    else           return o + NW'(1);
  endfunction

  assign c_nxt = adv({2'b00, col_off}, col_code, bayer);
  assign r_one = adv({2'b00, row_off}, row_code, bayer);
  assign r_two = adv(r_one, row_code, bayer);
  assign r_nxt = interlace ? r_two : r_one;

  assign c_end = c_nxt >= {2'b00, win_w};
  assign r_end = r_nxt >= {2'b00, win_h};

  assign par_nxt   = interlace & ~field_par;
  assign first_row = !par_nxt ? '0 :
                     bayer    ? AW'(1) : (AW'(1) << row_code);

  assign col_addr = col_org + col_off;
  assign row_addr = row_org + row_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_off    <= '0;
      row_off    <= '0;
      field_par  <= 1'b0;
      row_done   <= 1'b0;
      field_done <= 1'b0;
    end else begin
      row_done   <= 1'b0;
      field_done <= 1'b0;
      if (step) begin
        if (!c_end) begin
          col_off <= c_nxt[AW-1:0];
        end else begin
          col_off  <= '0;
          row_done <= 1'b1;
          if (!r_end) begin
            row_off <= r_nxt[AW-1:0];
          end else begin
            row_off    <= first_row;
            field_done <= 1'b1;
            field_par  <= par_nxt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/subsample_addr_seq_chk.sv
module subsample_addr_seq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic [AW-1:0] col_org,
  input logic [AW-1:0] row_org,
  input logic [AW-1:0] win_w,
  input logic [AW-1:0] win_h,
  input logic          interlace,
  input logic [AW-1:0] col_addr,
  input logic [AW-1:0] row_addr,
  input logic          row_done,
  input logic          field_done,
  input logic          field_par
);
  logic [AW-1:0] col_rel, row_rel;
  assign col_rel = col_addr - col_org;
  assign row_rel = row_addr - row_org;

  // R5
  col_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_rel < win_w);
  // R5
  row_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_rel < win_h);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(col_addr) && $stable(row_addr) && $stable(field_par)
              && !row_done && !field_done);
  // R7
  field_ends_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |-> row_done);
  // R6
  row_start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> col_addr == col_org);
  // R9
  parity_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_done && interlace |-> field_par != $past(field_par));
  // R9
  progressive_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !interlace |-> !field_par);
endmodule

bind subsample_addr_seq subsample_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .col_org(col_org),
  .row_org(row_org), .win_w(win_w), .win_h(win_h), .interlace(interlace),
  .col_addr(col_addr), .row_addr(row_addr), .row_done(row_done),
  .field_done(field_done), .field_par(field_par));

// File: tb/subsample_addr_seq_bench.sv
module subsample_addr_seq_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step = 1'b0;
  logic [AW-1:0] col_org = '0, row_org = '0, win_w = 10'd1, win_h = 10'd1;
  logic [1:0]    col_code = '0, row_code = '0;
  logic          bayer = 1'b0, interlace = 1'b0;
  logic [AW-1:0] col_addr, row_addr;
  logic          row_done, field_done, field_par;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  subsample_addr_seq #(.AW(AW)) u_subsample_addr_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .col_org(col_org),
    .row_org(row_org), .win_w(win_w), .win_h(win_h), .col_code(col_code),
    .row_code(row_code), .bayer(bayer), .interlace(interlace),
    .col_addr(col_addr), .row_addr(row_addr), .row_done(row_done),
    .field_done(field_done), .field_par(field_par));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // keep rule taken straight from R3 / R4
  function automatic bit keep(input int o, input int code, input bit bay);
    if (bay) return (o % (2 << code)) < 2;
    return (o % (1 << code)) == 0;
  endfunction

  task automatic setup(input int co, input int ro, input int w, input int h,
                       input int cc, input int rc, input bit bay, input bit il);
    @(negedge clk);
    rst_n = 1'b0; step = 1'b0;
    col_org = AW'(co); row_org = AW'(ro); win_w = AW'(w); win_h = AW'(h);
    col_code = 2'(cc); row_code = 2'(rc); bayer = bay; interlace = il;
    @(negedge clk);
    chk(col_addr == AW'(co), "R1 col in reset", int'(col_addr), co);
    chk(row_addr == AW'(ro), "R1 row in reset", int'(row_addr), ro);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(col_addr == AW'(co) && row_addr == AW'(ro), "R1 addr after reset",
        int'(col_addr), co);
    chk(!row_done && !field_done && !field_par, "R1 flags after reset",
        int'({row_done, field_done, field_par}), 0);
  endtask

  // walk nf fields with the current configuration, checking every pixel
  task automatic walk(input int nf, input string req);
    int cl[64]; int rl[64]; int nc = 0; int nr = 0;
    for (int c = 0; c < int'(win_w); c++) if (keep(c, int'(col_code), bayer)) begin
      cl[nc] = c; nc++;
    end
    for (int r = 0; r < int'(win_h); r++) if (keep(r, int'(row_code), bayer)) begin
      rl[nr] = r; nr++;
    end
    for (int f = 0; f < nf; f++) begin
      int p = interlace ? (f % 2) : 0;
      int fr[64]; int nfr = 0;
      for (int i = p; i < nr; i += (interlace ? 2 : 1)) begin
        fr[nfr] = rl[i]; nfr++;
      end
      for (int ri = 0; ri < nfr; ri++) begin
        for (int ci = 0; ci < nc; ci++) begin
          bit lc = (ci == nc - 1);
          bit lf = lc && (ri == nfr - 1);
          chk(int'(row_addr) == int'(row_org) + fr[ri],
              interlace ? "R8 row order" : "R7 row order",
              int'(row_addr), int'(row_org) + fr[ri]);
          chk(int'(col_addr) == int'(col_org) + cl[ci], req,
              int'(col_addr), int'(col_org) + cl[ci]);
          chk(field_par == p[0], "R9 parity", int'(field_par), p);
          step = 1'b1;
          @(negedge clk);
          step = 1'b0;
          chk(row_done == lc, "R6 row_done pulse", int'(row_done), int'(lc));
          chk(field_done == lf, "R7 field_done pulse", int'(field_done), int'(lf));
          @(negedge clk);
          chk(!row_done && !field_done, "R2 flags low when idle",
              int'({row_done, field_done}), 0);
        end
      end
    end
    chk(int'(row_addr) == int'(row_org) + (interlace && nf % 2 == 1 ? rl[1] : 0),
        "R7 wrap to first row", int'(row_addr),
        int'(row_org) + (interlace && nf % 2 == 1 ? rl[1] : 0));
  endtask

  task automatic t_mono_full;
    setup(10, 20, 5, 3, 0, 0, 0, 0);
    walk(2, "R3 mono full columns");
  endtask

  task automatic t_mono_mixed;
    setup(3, 7, 9, 9, 1, 2, 0, 0);
    walk(1, "R3 mono half/quarter columns");
    setup(0, 0, 17, 17, 3, 3, 0, 0);
    walk(1, "R3 mono eighth columns");
  endtask

  task automatic t_bayer;
    setup(4, 6, 9, 10, 2, 2, 1, 0);
    walk(1, "R4 R5 bayer quarter, truncated tile");
    setup(0, 0, 32, 32, 3, 3, 1, 0);
    walk(1, "R4 bayer eighth");
    setup(100, 50, 6, 4, 1, 0, 1, 0);
    walk(1, "R4 bayer half columns full rows");
  endtask

  task automatic t_interlace;
    setup(8, 2, 3, 5, 0, 0, 0, 1);
    walk(4, "R8 interlace mono columns");
    setup(1, 1, 4, 9, 1, 1, 1, 1);
    walk(3, "R8 interlace bayer columns");
  endtask

  task automatic t_hold;
    logic [AW-1:0] c0, r0;
    setup(5, 5, 8, 8, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step = 1'b1; @(negedge clk); step = 1'b0; @(negedge clk);
    end
    c0 = col_addr; r0 = row_addr;
    repeat (6) @(negedge clk);
    chk(col_addr == c0 && col_addr == 10'd8, "R2 col held without step",
        int'(col_addr), 8);
    chk(row_addr == r0 && !row_done && !field_done, "R2 row held without step",
        int'(row_addr), int'(r0));
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    t_mono_full();
    t_mono_mixed();
    t_bayer();
    t_interlace();
    t_hold();
    finish_run();
  end
endmodule